// File: doc/BRIEF.md
# I2C Register-Write Target with CRC-8 Check

This block is a write-only I2C target that runs entirely in the system clock domain. It oversamples the bus clock and data lines and finds Start and Stop conditions. When an address byte matches its configured 7-bit address with the write direction bit, it acknowledges. It then treats the next byte as a register pointer, and every following data byte as a write to the location the pointer names. The pointer steps by one after each committed byte, so a run of data bytes before the Stop fills consecutive registers.

When the checksum option is enabled, each data byte must be followed by a CRC-8 byte. The first checksum of a transaction covers the address byte, the register byte and the first data byte. Each later checksum covers only its own data byte. The data byte reaches the register write port only after its checksum matches. A bad checksum is not acknowledged, the held byte is dropped, and the target stays silent until the next Start. The data line is driven only as an open-drain pull-down, through an output-enable pin.

Top module: `i2c_crc_target`

## Requirements
- R1: After reset, `sda_oe` is 0 and `wr_stb` is 0.
- R2: An address byte is acknowledged only when bits [7:1] equal `cfg_addr` and bit 0 (direction) is 0. With `cfg_addr` = 0x08 that is the byte 0x10 only. Any other address byte, including 0x11, is not acknowledged. No later byte up to the next Start is acknowledged, and no write is produced.
- R3: The byte after an acknowledged address loads the register pointer. Each committed data byte is written at the pointer, and the pointer then advances by one, wrapping from 0xFF to 0x00.
- R4: With `cfg_crc_en` = 0, every data byte is acknowledged and produces exactly one single-cycle `wr_stb` pulse carrying the pointer and the byte.
- R5: The checksum is CRC-8 with polynomial 0x07, initial value 0, processed MSB first. The checksum after the first data byte covers the address byte, the register byte and that data byte. The checksum after any later data byte covers that data byte alone.
- R6: With `cfg_crc_en` = 1, a data byte is acknowledged but not written. It is written only when the following byte equals the expected checksum, and that checksum byte is acknowledged.
- R7: A checksum byte that differs from the expected value is not acknowledged. The held data byte is discarded, and no byte is acknowledged or written until the next Start.
- R8: A Start (SDA falling while SCL is high) seen in any state, including in the middle of a byte, begins a new address phase. A Stop (SDA rising while SCL is high) returns the target to idle.
- R9: The acknowledge pull-down is asserted after the SCL falling edge that ends the eighth bit of a byte, and released after the SCL falling edge that ends the ninth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| cfg_addr | input | 7 | 7-bit target address |
| cfg_crc_en | input | 1 | 1 requires a CRC-8 byte after each data byte |
| wr_addr | output | 8 | Register address of the write |
| wr_data | output | 8 | Data of the write |
| wr_stb | output | 1 | One-cycle write strobe |

## Verification
Each bus edge passes through two synchronizer flops and one edge-compare flop. As a result, `sda_oe` and `wr_stb` change on the third rising clock edge after the bench moves SCL low. The bench holds each SCL phase for four clocks, so the acknowledge level has settled well before the bench raises SCL, and it reads that level just before SCL falls again. Write strobes are captured at the falling clock edge into a log. After every transaction the bench compares the log against a list computed from the pointer and CRC arithmetic of the requirements. In checksum mode it also reads the log between a data byte and its CRC byte, to show that the write has not yet happened.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_REG  = 3'd2,
    ST_DATA = 3'd3,
    ST_CRC  = 3'd4,
    ST_SKIP = 3'd5
  } tgt_state_e;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_p, sda_p;
  logic              scl_q, sda_q, scl_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_p <= '1;
          sda_p <= '1;
        end else begin
          scl_p <= scl_i;
          sda_p <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_p <= '1;
          sda_p <= '1;
        end else begin
          scl_p <= {scl_p[STAGES-2:0], scl_i};
          sda_p <= {sda_p[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_p[STAGES-1];
  assign sda_s = sda_p[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = ~scl_q & scl_s;
    scl_fall  = scl_q & ~scl_s;
    start_det = scl_q & scl_s & sda_q & ~sda_s;
    stop_det  = scl_q & scl_s & ~sda_q & sda_s;
  end

endmodule

// File: rtl/i2ct_crc8.sv
module i2ct_crc8 #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic [7:0] crc_in,
  input  logic [7:0] data_in,
  output logic [7:0] crc_out
);

  logic [7:0] stage [0:8];

  assign stage[0] = crc_in ^ data_in;

  genvar gi;
  generate
    for (gi = 0; gi < 8; gi++) begin : g_bit
      assign stage[gi+1] = stage[gi][7] ? ({stage[gi][6:0], 1'b0} ^ POLY)
                                        : {stage[gi][6:0], 1'b0};
    end
  endgenerate

  assign crc_out = stage[8];

endmodule

// File: rtl/i2c_crc_target.sv
module i2c_crc_target
  import i2ct_pkg::*;
#(
  parameter int unsigned REG_AW      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  CRC_POLY    = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [6:0]        cfg_addr,
  input  logic              cfg_crc_en,
  output logic [REG_AW-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_stb
);

  localparam int unsigned BIT_W = $clog2(BYTE_W + 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tgt_state_e        st_q, st_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [7:0]        sh_q, sh_d;
  logic              ackph_q, ackph_d;
  logic              oe_q, oe_d;
  logic [REG_AW-1:0] ptr_q, ptr_d;
  logic [7:0]        crc_q, crc_d;
  logic [7:0]        hold_q, hold_d;
  logic              first_q, first_d;
  logic              stb_q, stb_d;
  logic [REG_AW-1:0] waddr_q, waddr_d;
  logic [7:0]        wdata_q, wdata_d;

  logic [7:0] crc_seed, crc_next;
  logic       byte_done, active;

  i2ct_crc8 #(.POLY(CRC_POLY)) u_crc (
    .crc_in  (crc_seed),
    .data_in (sh_q),
    .crc_out (crc_next)
  );

  always_comb begin
    unique case (st_q)
      ST_REG:  crc_seed = crc_q;
      ST_DATA: crc_seed = first_q ? crc_q : 8'h00;
      default: crc_seed = 8'h00;
    endcase
  end

  assign active    = (st_q == ST_ADDR) || (st_q == ST_REG) ||
                     (st_q == ST_DATA) || (st_q == ST_CRC);
  assign byte_done = scl_fall && !ackph_q && (bit_q == BIT_LAST) && active;

  // next state
  always_comb begin
    st_d    = st_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    ackph_d = ackph_q;
    oe_d    = oe_q;
    ptr_d   = ptr_q;
    crc_d   = crc_q;
    hold_d  = hold_q;
    first_d = first_q;
    stb_d   = 1'b0;
    waddr_d = waddr_q;
    wdata_d = wdata_q;

    if (start_det) begin
      st_d    = ST_ADDR;
      bit_d   = '0;
      ackph_d = 1'b0;
      oe_d    = 1'b0;
      first_d = 1'b1;
    end else if (stop_det) begin
      st_d    = ST_IDLE;
      bit_d   = '0;
      ackph_d = 1'b0;
      oe_d    = 1'b0;
    end else if (active) begin
      if (scl_rise && !ackph_q && (bit_q != BIT_LAST)) begin
        sh_d  = {sh_q[6:0], sda_s};
        bit_d = bit_q + 1'b1;
      end else if (scl_fall && ackph_q) begin
        ackph_d = 1'b0;
        oe_d    = 1'b0;
        bit_d   = '0;
      end else if (byte_done) begin
        ackph_d = 1'b1;
        oe_d    = 1'b1;
        unique case (st_q)
          ST_ADDR: begin
            if ((sh_q[7:1] == cfg_addr) && !sh_q[0]) begin
              crc_d = crc_next;
              st_d  = ST_REG;
            end else begin
              oe_d    = 1'b0;
              ackph_d = 1'b0;
              st_d    = ST_SKIP;
            end
          end
          ST_REG: begin
            ptr_d = sh_q[REG_AW-1:0];
            crc_d = crc_next;
            st_d  = ST_DATA;
          end
          ST_DATA: begin
            if (cfg_crc_en) begin
              hold_d = sh_q;
              crc_d  = crc_next;
              st_d   = ST_CRC;
            end else begin
              stb_d   = 1'b1;
              waddr_d = ptr_q;
              wdata_d = sh_q;
              ptr_d   = ptr_q + 1'b1;
            end
          end
          ST_CRC: begin
            if (sh_q == crc_q) begin
              stb_d   = 1'b1;
              waddr_d = ptr_q;
              wdata_d = hold_q;
              ptr_d   = ptr_q + 1'b1;
              first_d = 1'b0;
              st_d    = ST_DATA;
            end else begin
              oe_d    = 1'b0;
              ackph_d = 1'b0;
              st_d    = ST_SKIP;
            end
          end
          default: st_d = ST_SKIP;
        endcase
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q    <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      ackph_q <= 1'b0;
      oe_q    <= 1'b0;
      ptr_q   <= '0;
      crc_q   <= '0;
      hold_q  <= '0;
      first_q <= 1'b1;
      stb_q   <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      st_q    <= st_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      ackph_q <= ackph_d;
      oe_q    <= oe_d;
      ptr_q   <= ptr_d;
      crc_q   <= crc_d;
      hold_q  <= hold_d;
      first_q <= first_d;
      stb_q   <= stb_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_stb  = stb_q;
  assign wr_addr = waddr_q;
  assign wr_data = wdata_q;

  // R4: a write strobe lasts one cycle
  p_stb_pulse_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_stb |=> !wr_stb);

  // R3: the pointer has moved one past the address just written
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_stb |-> (ptr_q == REG_AW'(wr_addr + 1'b1)));

  // R6: in checksum mode a write only follows a checksum byte
  p_crc_gate_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_stb && $past(cfg_crc_en)) |-> ($past(st_q) == ST_CRC));

  // R7: no pull-down while idle or ignoring bytes
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((st_q == ST_IDLE) || (st_q == ST_SKIP)) |-> !sda_oe);

  // R8: a Start always reopens the address phase with the line released
  p_start_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    start_det |=> ((st_q == ST_ADDR) && !sda_oe && !wr_stb));

endmodule

// File: tb/tb_i2c_crc_target.sv
`timescale 1ns/1ps
module tb_i2c_crc_target;

  localparam int HP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_drv = 1'b1;
  logic       sda_line;
  logic       sda_oe;
  logic [6:0] cfg_addr = 7'h08;
  logic       cfg_crc_en = 1'b0;
  logic [7:0] wr_addr, wr_data;
  logic       wr_stb;

  always #2 clk = ~clk;

  assign sda_line = sda_drv & ~sda_oe;

  i2c_crc_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .cfg_addr(cfg_addr), .cfg_crc_en(cfg_crc_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_stb(wr_stb)
  );

  int checks = 0;
  int errors = 0;
  int log_n = 0;
  logic [7:0] log_a [0:63];
  logic [7:0] log_d [0:63];
  logic [7:0] exp_a [0:63];
  logic [7:0] exp_d [0:63];
  int exp_n = 0;

  always @(negedge clk) begin
    if (rst_n && wr_stb && log_n < 64) begin
      log_a[log_n] = wr_addr;
      log_d[log_n] = wr_data;
      log_n = log_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r = c ^ b;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic waitp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; waitp();
    scl = 1'b1; waitp();
    sda_drv = 1'b0; waitp();
    scl = 1'b0; waitp();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; waitp();
    scl = 1'b1; waitp();
    sda_drv = 1'b1; waitp();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_drv = b[i]; waitp();
      scl = 1'b1; waitp();
      scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    waitp();
    sda_drv = 1'b1; waitp();
    scl = 1'b1; waitp();
    ack = ~sda_line;
    scl = 1'b0; waitp();
  endtask

  task automatic expect_wr(input logic [7:0] a, input logic [7:0] d);
    exp_a[exp_n] = a;
    exp_d[exp_n] = d;
    exp_n++;
  endtask

  task automatic compare_log(input string req);
    check(log_n == exp_n, req, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      check(log_a[i] == exp_a[i], req, log_a[i], exp_a[i]);
      check(log_d[i] == exp_d[i], req, log_d[i], exp_d[i]);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    bit ack_oe_mid;
    logic [7:0] c;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1
    check(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    check(wr_stb == 1'b0, "R1 wr_stb", wr_stb, 0);

    // R2: sweep every address byte
    for (int a = 0; a < 256; a++) begin
      bit ack2;
      bus_start();
      send_byte(8'(a), ack);
      check(ack == (a == 8'h10), "R2 addr ack", ack, a == 8'h10);
      send_byte(8'h55, ack2);
      check(ack2 == (a == 8'h10), "R2 follow byte", ack2, a == 8'h10);
      bus_stop();
    end
    compare_log("R2 no writes");

    // R2: other configured address
    cfg_addr = 7'h3A;
    bus_start(); send_byte(8'h74, ack);
    check(ack, "R2 cfg addr 0x3A", ack, 1);
    bus_stop();
    bus_start(); send_byte(8'h10, ack);
    check(!ack, "R2 old addr rejected", ack, 0);
    bus_stop();
    cfg_addr = 7'h08;

    // R9: acknowledge window timing
    bus_start();
    send_bits(8'h10, 8);
    repeat (2) @(negedge clk);
    check(sda_oe == 1'b0, "R9 not before latency", sda_oe, 0);
    repeat (2) @(negedge clk);
    ack_oe_mid = sda_oe;
    check(ack_oe_mid, "R9 driven after 8th fall", sda_oe, 1);
    sda_drv = 1'b1; waitp();
    scl = 1'b1; waitp();
    check(sda_oe == 1'b1, "R9 held while scl high", sda_oe, 1);
    scl = 1'b0; waitp();
    check(sda_oe == 1'b0, "R9 released after 9th fall", sda_oe, 0);
    bus_stop();

    // R3 R4: block write without checksum, several lengths
    for (int len = 1; len <= 4; len++) begin
      logic [7:0] base;
      base = 8'(len * 16 + 3);
      bus_start();
      send_byte(8'h10, ack);
      send_byte(base, ack);
      for (int k = 0; k < len; k++) begin
        d = 8'(len * 37 + k * 11);
        send_byte(d, ack);
        check(ack, "R4 data ack", ack, 1);
        expect_wr(base + 8'(k), d);
      end
      bus_stop();
    end
    compare_log("R3 R4 block write");

    // R3: pointer wrap
    bus_start();
    send_byte(8'h10, ack); send_byte(8'hFF, ack);
    send_byte(8'hC1, ack); expect_wr(8'hFF, 8'hC1);
    send_byte(8'hC2, ack); expect_wr(8'h00, 8'hC2);
    bus_stop();
    compare_log("R3 wrap");

    // R8: Start in mid byte restarts
    bus_start();
    send_byte(8'h10, ack); send_byte(8'h50, ack);
    send_bits(8'hF0, 4);
    waitp();
    bus_start();
    send_byte(8'h10, ack);
    check(ack, "R8 restart addr ack", ack, 1);
    send_byte(8'h60, ack); send_byte(8'h77, ack);
    expect_wr(8'h60, 8'h77);
    bus_stop();
    compare_log("R8 restart");

    // R5 R6: checksum block write
    cfg_crc_en = 1'b1;
    bus_start();
    send_byte(8'h10, ack);
    send_byte(8'h20, ack);
    c = crc8(crc8(crc8(8'h00, 8'h10), 8'h20), 8'hA5);
    send_byte(8'hA5, ack);
    check(ack, "R6 data ack", ack, 1);
    check(log_n == exp_n, "R6 no write before crc", log_n, exp_n);
    send_byte(c, ack);
    check(ack, "R5 first crc ack", ack, 1);
    expect_wr(8'h20, 8'hA5);
    for (int k = 0; k < 3; k++) begin
      d = 8'(8'h3C + k * 29);
      send_byte(d, ack);
      send_byte(crc8(8'h00, d), ack);
      check(ack, "R5 later crc data only", ack, 1);
      expect_wr(8'h21 + 8'(k), d);
    end
    bus_stop();
    compare_log("R5 R6 crc block");

    // R7: bad checksum
    bus_start();
    send_byte(8'h10, ack); send_byte(8'h40, ack);
    send_byte(8'h11, ack);
    c = crc8(crc8(crc8(8'h00, 8'h10), 8'h40), 8'h11);
    send_byte(c ^ 8'h01, ack);
    check(!ack, "R7 bad crc nack", ack, 0);
    send_byte(8'h22, ack);
    check(!ack, "R7 ignore after bad", ack, 0);
    send_byte(crc8(8'h00, 8'h22), ack);
    check(!ack, "R7 ignore crc", ack, 0);
    bus_stop();
    compare_log("R7 dropped");

    // R5: a later data byte checked with the full-chain checksum is rejected
    bus_start();
    send_byte(8'h10, ack); send_byte(8'h08, ack);
    c = crc8(crc8(crc8(8'h00, 8'h10), 8'h08), 8'h01);
    send_byte(8'h01, ack); send_byte(c, ack);
    expect_wr(8'h08, 8'h01);
    send_byte(8'h02, ack);
    send_byte(crc8(c, 8'h02), ack);
    check(ack == (crc8(c, 8'h02) == crc8(8'h00, 8'h02)), "R5 chained crc rejected", ack, 0);
    bus_stop();
    compare_log("R5 chained");

    // R7 R8: recovery after Start
    bus_start();
    send_byte(8'h10, ack); send_byte(8'h90, ack);
    send_byte(8'h5A, ack);
    send_byte(crc8(crc8(crc8(8'h00, 8'h10), 8'h90), 8'h5A), ack);
    check(ack, "R8 recovery crc ack", ack, 1);
    expect_wr(8'h90, 8'h5A);
    bus_stop();
    compare_log("R8 recovery");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule